// File: doc/BRIEF.md
# Host Parallel Port with DMA Engine

This block is the host-facing parallel port of a signal processor. An external host selects one of sixteen register slots with a 4-bit select and moves a byte or a halfword per access. Behind the slots sit an address pointer, an address extension, a primary and a secondary data register, an error mask, an error status, a control register and an interrupt-exchange register. Two control bits pick one of four slot maps, so the same select reaches different registers depending on how the port is configured.

Completing a register (writing or reading its upper byte, or the whole halfword) can start a memory access on a 24-bit byte-addressed bus, as a halfword or a full word. The access can advance the address afterwards. Data-full and interrupt-full flags in the control register track these exchanges and are mirrored on two flag pins for the host. A rising edge on the run bit of the control register soft-resets the port. While that bit is low, the processing core is held.

The memory side uses one request/acknowledge handshake. The port stalls the host, through a busy output, until the acknowledge arrives.

Top module: `host_pio_dma`

## Requirements
- R1: The map index is {ctrl[9], ctrl[1]}. In map 0, selects 0..7 reach pointer lo, pointer hi, data lo, data hi, mask lo, mask hi, status lo and control lo, and selects 8..15 all reach the interrupt register high byte.
- R2: Map 1 keeps selects 0..7 of map 0. Select 8 reaches interrupt lo, 9 interrupt hi, 10 control hi, 11 extension lo, 12 second-data lo and 13 second-data hi. Selects 14 and 15 are reserved.
- R3: In map 2 every select is reserved. Reads return 16'h00FF and writes change nothing, the control register included.
- R4: In map 3, accesses are full halfwords. Select 0 reaches pointer, 2 data, 4 mask, 6 status (low byte only), 7 control, 8 interrupt, 11 extension (low byte only) and 12 second data. Every other select reads 16'hFFFF.
- R5: In maps 0..2 a write takes its byte from host_wdata[7:0], and a read returns the byte on host_rdata[7:0] with bits 15:8 at zero. A read of the pointer always shows bit 0 as 1.
- R6: Completing a pointer write with ctrl[3] set loads from memory. In halfword mode the address has bit 0 cleared and the data register takes rdata[15:0]. In word mode (ctrl[8]) the address has bits 1:0 cleared, the data register takes rdata[31:16] and the second data register takes rdata[15:0]. The load sets ctrl[5] and leaves the flag pins untouched.
- R7: Completing a data-register write with ctrl[3] set stores to memory: the data register as a halfword, or in word mode {data, second data}. The store clears ctrl[5]. The address then advances and the pins are updated.
- R8: With ctrl[4] set, an advance adds 2 (4 in word mode) to the 16-bit pointer, and a carry out increments the extension. The memory address is {extension, pointer}.
- R9: A data-register read that touches the low byte (low byte or full) advances the address. One that touches the high byte (high or full) then loads from memory when ctrl[3] is set and updates the pins. The returned value is the data register as it was before the access.
- R10: Completing an interrupt-register write sets ctrl[6]. Reading its high byte or full halfword clears ctrl[6]. Both update the pins.
- R11: A host write to the control register never changes ctrl[6:5].
- R12: flag_pins = {ctrl[6], ctrl[5]}, taken only at pin-update events and only while ctrl[2] is set. pins_chg pulses for one cycle when the driven value changes.
- R13: A 0-to-1 change of ctrl[0] by a host write sets control to 16'h0001, status to 0 and mask to 16'hFFFF. core_run equals ctrl[0]. Hardware reset gives the same values, with the other registers and the pins at zero.
- R14: At most one memory access is outstanding. mem_req, mem_addr, mem_we and mem_word hold steady until mem_ack, and host_busy is high for that whole time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 4 | Register slot select |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the current select |
| host_busy | output | 1 | Memory access in flight; strobes must wait |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_word | output | 1 | 1 = 32-bit access, 0 = 16-bit access |
| mem_addr | output | 24 | Byte address, aligned to the size |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| flag_pins | output | 2 | {interrupt-full, data-full} as seen by the host |
| pins_chg | output | 1 | One-cycle pulse when flag_pins changed |
| core_run | output | 1 | Core may run (ctrl[0]) |

## Verification
The assertions assume the host issues strobes only while host_busy is low, never raises read and write together, and that mem_ack arrives only while mem_req is high, once per request. The stimulus waits out busy after each access. The memory responder answers only an open request, after a random delay of zero to two cycles, with data computed from the address. Random traffic runs in the full-halfword map with word transfers, so every store and load address and the pointer carry into the extension can be predicted.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [3:0] {
        RG_PTR, RG_EXT, RG_DAT, RG_DAT2, RG_EMASK, RG_ESTAT, RG_CTRL, RG_IRQ, RG_NONE
    } reg_e;

    typedef enum logic [1:0] {
        LN_LO, LN_HI, LN_FULL
    } lane_e;

    typedef struct packed {
        reg_e  id;
        lane_e lane;
    } slot_t;

    // control register bit positions
    localparam int CB_RUN   = 0;
    localparam int CB_MAP   = 1;
    localparam int CB_ENI   = 2;
    localparam int CB_DMA   = 3;
    localparam int CB_AUTO  = 4;
    localparam int CB_DFULL = 5;
    localparam int CB_IFULL = 6;
    localparam int CB_WIDE  = 8;
    localparam int CB_PORT  = 9;

    localparam logic [15:0] CTRL_RST  = 16'h0001;
    localparam logic [15:0] EMASK_RST = 16'hFFFF;

    function automatic slot_t mk(input reg_e id, input lane_e lane);
        slot_t s;
        s.id   = id;
        s.lane = lane;
        return s;
    endfunction

    function automatic slot_t pio_decode(input logic [1:0] mode, input logic [3:0] sel);
        slot_t s;
        s = mk(RG_NONE, LN_FULL);
        if (mode == 2'd0 || mode == 2'd1) begin
            if (!sel[3]) begin
                case (sel[2:0])
                    3'd0: s = mk(RG_PTR, LN_LO);
                    3'd1: s = mk(RG_PTR, LN_HI);
                    3'd2: s = mk(RG_DAT, LN_LO);
                    3'd3: s = mk(RG_DAT, LN_HI);
                    3'd4: s = mk(RG_EMASK, LN_LO);
                    3'd5: s = mk(RG_EMASK, LN_HI);
                    3'd6: s = mk(RG_ESTAT, LN_LO);
                    default: s = mk(RG_CTRL, LN_LO);
                endcase
            end else if (mode == 2'd0) begin
                s = mk(RG_IRQ, LN_HI);
            end else begin
                case (sel[2:0])
                    3'd0: s = mk(RG_IRQ, LN_LO);
                    3'd1: s = mk(RG_IRQ, LN_HI);
                    3'd2: s = mk(RG_CTRL, LN_HI);
                    3'd3: s = mk(RG_EXT, LN_LO);
                    3'd4: s = mk(RG_DAT2, LN_LO);
                    3'd5: s = mk(RG_DAT2, LN_HI);
                    default: s = mk(RG_NONE, LN_FULL);
                endcase
            end
        end else if (mode == 2'd3) begin
            case (sel)
                4'd0:  s = mk(RG_PTR, LN_FULL);
                4'd2:  s = mk(RG_DAT, LN_FULL);
                4'd4:  s = mk(RG_EMASK, LN_FULL);
                4'd6:  s = mk(RG_ESTAT, LN_LO);
                4'd7:  s = mk(RG_CTRL, LN_FULL);
                4'd8:  s = mk(RG_IRQ, LN_FULL);
                4'd11: s = mk(RG_EXT, LN_LO);
                4'd12: s = mk(RG_DAT2, LN_FULL);
                default: s = mk(RG_NONE, LN_FULL);
            endcase
        end
        return s;
    endfunction

    // byte data travels on bits 7:0 of the host bus in the narrow lanes
    function automatic logic [15:0] lane_merge(input logic [15:0] old, input logic [15:0] wd,
                                               input lane_e lane);
        case (lane)
            LN_LO:   return {old[15:8], wd[7:0]};
            LN_HI:   return {wd[7:0], old[7:0]};
            default: return wd;
        endcase
    endfunction

    function automatic logic [15:0] lane_pick(input logic [15:0] v, input lane_e lane);
        case (lane)
            LN_LO:   return {8'h00, v[7:0]};
            LN_HI:   return {8'h00, v[15:8]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/pio_regmap.sv
module pio_regmap
    import pio_pkg::*;
#(
    parameter int EXT_W = 8,
    parameter int ST_W  = 8
) (
    input  logic [1:0]       mode,
    input  logic [3:0]       sel,
    input  logic [15:0]      ptr,
    input  logic [EXT_W-1:0] ext,
    input  logic [15:0]      dat,
    input  logic [15:0]      dat2,
    input  logic [15:0]      emask,
    input  logic [ST_W-1:0]  estat,
    input  logic [15:0]      ctrl,
    input  logic [15:0]      irq,
    output slot_t            slot,
    output logic [15:0]      rdata
);
    localparam logic [15:0] NONE_NARROW = 16'h00FF;
    localparam logic [15:0] NONE_WIDE   = 16'hFFFF;

    logic [15:0] raw;

    assign slot = pio_decode(mode, sel);

    always_comb begin
        case (slot.id)
            RG_PTR:   raw = ptr | 16'h0001;
            RG_EXT:   raw = 16'(ext);
            RG_DAT:   raw = dat;
            RG_DAT2:  raw = dat2;
            RG_EMASK: raw = emask;
            RG_ESTAT: raw = 16'(estat);
            RG_CTRL:  raw = ctrl;
            RG_IRQ:   raw = irq;
            default:  raw = '0;
        endcase
        if (slot.id == RG_NONE)
            rdata = (mode == 2'd3) ? NONE_WIDE : NONE_NARROW;
        else
            rdata = lane_pick(raw, slot.lane);
    end

endmodule

// File: rtl/pio_addr_step.sv
module pio_addr_step #(
    parameter int PTR_W = 16,
    parameter int EXT_W = 8,
    localparam int ADDR_W = PTR_W + EXT_W
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [EXT_W-1:0]  ext,
    input  logic              wide,
    output logic [ADDR_W-1:0] addr,
    output logic [PTR_W-1:0]  ptr_next,
    output logic [EXT_W-1:0]  ext_next
);
    logic [ADDR_W-1:0] raw;
    logic [PTR_W:0]    sum;

    assign raw  = {ext, ptr};
    assign addr = wide ? {raw[ADDR_W-1:2], 2'b00} : {raw[ADDR_W-1:1], 1'b0};

    assign sum      = {1'b0, ptr} + (wide ? (PTR_W+1)'(4) : (PTR_W+1)'(2));
    assign ptr_next = sum[PTR_W-1:0];
    assign ext_next = ext + EXT_W'(sum[PTR_W]);

endmodule

// File: rtl/pio_flag_pins.sv
module pio_flag_pins #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd,
    input  logic         en,
    input  logic [N-1:0] flags,
    output logic [N-1:0] pins,
    output logic         chg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pins <= '0;
            chg  <= 1'b0;
        end else begin
            chg <= 1'b0;
            if (upd && en && flags != pins) begin
                pins <= flags;
                chg  <= 1'b1;
            end
        end
    end

    // R12: a notification always marks a real change of the pins
    p_chg_real_r12: assert property (@(posedge clk) disable iff (rst)
        chg |-> pins != $past(pins));

    // R12: pins move only after an update event
    p_pins_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(pins));

endmodule

// File: rtl/host_pio_dma.sv
module host_pio_dma
    import pio_pkg::*;
#(
    parameter int ADDR_W = 24,
    localparam int PTR_W = 16,
    localparam int EXT_W = ADDR_W - PTR_W,
    localparam int ST_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              host_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic [1:0]        flag_pins,
    output logic              pins_chg,
    output logic              core_run
);
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [EXT_W-1:0] ext_q, ext_d;
    logic [15:0]      dat_q, dat_d, dat2_q, dat2_d;
    logic [15:0]      emask_q, emask_d, ctrl_q, ctrl_d, irq_q, irq_d;
    logic [ST_W-1:0]  estat_q, estat_d;
    logic             busy_q, busy_d, op_load_q, op_load_d, op_pins_q, op_pins_d;
    logic             pin_upd;

    slot_t            slot;
    logic [1:0]       mode;
    logic [PTR_W-1:0] ptr_step;
    logic [EXT_W-1:0] ext_step;
    logic             complete, low_touch;
    logic [15:0]      tmp;

    assign mode = {ctrl_q[CB_PORT], ctrl_q[CB_MAP]};

    pio_regmap #(.EXT_W(EXT_W), .ST_W(ST_W)) u_map (
        .mode(mode), .sel(host_sel), .ptr(ptr_q), .ext(ext_q), .dat(dat_q), .dat2(dat2_q),
        .emask(emask_q), .estat(estat_q), .ctrl(ctrl_q), .irq(irq_q),
        .slot(slot), .rdata(host_rdata)
    );

    pio_addr_step #(.PTR_W(PTR_W), .EXT_W(EXT_W)) u_step (
        .ptr(ptr_q), .ext(ext_q), .wide(ctrl_q[CB_WIDE]),
        .addr(mem_addr), .ptr_next(ptr_step), .ext_next(ext_step)
    );

    pio_flag_pins #(.N(2)) u_pins (
        .clk(clk), .rst(rst), .upd(pin_upd), .en(ctrl_d[CB_ENI]),
        .flags({ctrl_d[CB_IFULL], ctrl_d[CB_DFULL]}),
        .pins(flag_pins), .chg(pins_chg)
    );

    assign complete  = (slot.lane != LN_LO);
    assign low_touch = (slot.lane != LN_HI);

    always_comb begin
        ptr_d     = ptr_q;
        ext_d     = ext_q;
        dat_d     = dat_q;
        dat2_d    = dat2_q;
        emask_d   = emask_q;
        estat_d   = estat_q;
        ctrl_d    = ctrl_q;
        irq_d     = irq_q;
        busy_d    = busy_q;
        op_load_d = op_load_q;
        op_pins_d = op_pins_q;
        pin_upd   = 1'b0;
        tmp       = '0;
        if (!busy_q) begin
            if (host_wr) begin
                case (slot.id)
                    RG_PTR: begin
                        ptr_d = lane_merge(ptr_q, host_wdata, slot.lane);
                        if (complete && ctrl_q[CB_DMA]) begin
                            busy_d    = 1'b1;
                            op_load_d = 1'b1;
                            op_pins_d = 1'b0;
                        end
                    end
                    RG_EXT: begin
                        tmp   = lane_merge(16'(ext_q), host_wdata, slot.lane);
                        ext_d = tmp[EXT_W-1:0];
                    end
                    RG_DAT: begin
                        dat_d = lane_merge(dat_q, host_wdata, slot.lane);
                        if (complete) begin
                            if (ctrl_q[CB_DMA]) begin
                                busy_d    = 1'b1;
                                op_load_d = 1'b0;
                                op_pins_d = 1'b1;
                            end else begin
                                if (ctrl_q[CB_AUTO]) begin
                                    ptr_d = ptr_step;
                                    ext_d = ext_step;
                                end
                                pin_upd = 1'b1;
                            end
                        end
                    end
                    RG_DAT2:  dat2_d  = lane_merge(dat2_q, host_wdata, slot.lane);
                    RG_EMASK: emask_d = lane_merge(emask_q, host_wdata, slot.lane);
                    RG_ESTAT: begin
                        tmp     = lane_merge(16'(estat_q), host_wdata, slot.lane);
                        estat_d = tmp[ST_W-1:0];
                    end
                    RG_CTRL: begin
                        tmp = lane_merge(ctrl_q, host_wdata, slot.lane);
                        tmp[CB_IFULL:CB_DFULL] = ctrl_q[CB_IFULL:CB_DFULL];
                        if (!ctrl_q[CB_RUN] && tmp[CB_RUN]) begin
                            ctrl_d  = CTRL_RST;
                            emask_d = EMASK_RST;
                            estat_d = '0;
                        end else begin
                            ctrl_d = tmp;
                        end
                    end
                    RG_IRQ: begin
                        irq_d = lane_merge(irq_q, host_wdata, slot.lane);
                        if (complete) begin
                            ctrl_d[CB_IFULL] = 1'b1;
                            pin_upd          = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else if (host_rd) begin
                case (slot.id)
                    RG_DAT: begin
                        if (low_touch && ctrl_q[CB_AUTO]) begin
                            ptr_d = ptr_step;
                            ext_d = ext_step;
                        end
                        if (complete) begin
                            if (ctrl_q[CB_DMA]) begin
                                busy_d    = 1'b1;
                                op_load_d = 1'b1;
                                op_pins_d = 1'b1;
                            end else begin
                                pin_upd = 1'b1;
                            end
                        end
                    end
                    RG_IRQ: begin
                        if (complete) begin
                            ctrl_d[CB_IFULL] = 1'b0;
                            pin_upd          = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end else if (mem_ack) begin
            busy_d = 1'b0;
            if (op_load_q) begin
                if (ctrl_q[CB_WIDE]) begin
                    dat_d  = mem_rdata[31:16];
                    dat2_d = mem_rdata[15:0];
                end else begin
                    dat_d = mem_rdata[15:0];
                end
                ctrl_d[CB_DFULL] = 1'b1;
                pin_upd          = op_pins_q;
            end else begin
                ctrl_d[CB_DFULL] = 1'b0;
                if (ctrl_q[CB_AUTO]) begin
                    ptr_d = ptr_step;
                    ext_d = ext_step;
                end
                pin_upd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            ext_q     <= '0;
            dat_q     <= '0;
            dat2_q    <= '0;
            emask_q   <= EMASK_RST;
            estat_q   <= '0;
            ctrl_q    <= CTRL_RST;
            irq_q     <= '0;
            busy_q    <= 1'b0;
            op_load_q <= 1'b0;
            op_pins_q <= 1'b0;
        end else begin
            ptr_q     <= ptr_d;
            ext_q     <= ext_d;
            dat_q     <= dat_d;
            dat2_q    <= dat2_d;
            emask_q   <= emask_d;
            estat_q   <= estat_d;
            ctrl_q    <= ctrl_d;
            irq_q     <= irq_d;
            busy_q    <= busy_d;
            op_load_q <= op_load_d;
            op_pins_q <= op_pins_d;
        end
    end

    assign host_busy = busy_q;
    assign mem_req   = busy_q;
    assign mem_we    = !op_load_q;
    assign mem_word  = ctrl_q[CB_WIDE];
    assign mem_wdata = ctrl_q[CB_WIDE] ? {dat_q, dat2_q} : {16'h0000, dat_q};
    assign core_run  = ctrl_q[CB_RUN];

    // R14: an open request holds its address and kind until acknowledged
    p_req_hold_r14: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_word));

    // R6: requested addresses are aligned to the transfer size
    p_align_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_word ? (mem_addr[1:0] == 2'b00) : !mem_addr[0]));

    // R6: a finished load leaves the data-full flag set
    p_load_full_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack && !mem_we |=> ctrl_q[CB_DFULL]);

    // R7: a finished store leaves the data-full flag clear
    p_store_empty_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack && mem_we |=> !ctrl_q[CB_DFULL]);

    // R11: host control writes keep both exchange flags while running
    p_flags_kept_r11: assert property (@(posedge clk) disable iff (rst)
        !busy_q && host_wr && slot.id == RG_CTRL && ctrl_q[CB_RUN]
        |=> ctrl_q[CB_IFULL:CB_DFULL] == $past(ctrl_q[CB_IFULL:CB_DFULL]));

endmodule

// File: tb/tb_host_pio_dma.sv
`timescale 1ns/1ps
module tb_host_pio_dma;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  host_sel = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_busy, mem_req, mem_we, mem_word, mem_ack = 1'b0;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic [1:0]  flag_pins;
    logic        pins_chg, core_run;

    int n_chk = 0, n_fail = 0, n_chg = 0, n_st = 0, n_ld = 0, dly = 0;
    bit done = 0;
    logic [23:0] w_addr;
    logic [31:0] w_data;
    logic        w_word;

    always #2 clk = ~clk;

    host_pio_dma dut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_busy(host_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .flag_pins(flag_pins), .pins_chg(pins_chg), .core_run(core_run)
    );

    function automatic logic [31:0] memf(input logic [23:0] a);
        return {a[7:0] ^ 8'hC3, a};
    endfunction

    // memory responder: acknowledges an open request after 0..2 cycles
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req && !rst) begin
                if (dly == 0) begin
                    mem_ack   = 1'b1;
                    mem_rdata = memf(mem_addr);
                    if (mem_we) begin
                        w_addr = mem_addr; w_data = mem_wdata; w_word = mem_word; n_st++;
                    end else n_ld++;
                    dly = $urandom % 3;
                end else dly--;
            end
        end
    end

    always @(negedge clk) if (!rst && pins_chg) n_chg++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [15:0] d);
        @(negedge clk);
        host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        while (host_busy) @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] s, output logic [15:0] v);
        @(negedge clk);
        host_sel = s; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
        while (host_busy) @(negedge clk);
    endtask

    task automatic hw_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [15:0] m_ptr, m_dat, m_dat2, m_emask;
        logic [7:0]  m_ext;
        logic [16:0] sum;
        logic [23:0] a;
        int c0, s0, l0;
        void'($urandom(32'd7351));
        hw_reset();

        // reset state (R13)
        chk("R13 core_run after reset", core_run, 1);
        chk("R13 pins after reset", flag_pins, 0);
        rd(4'd7, v); chk("R13 ctrl lo after reset", v, 16'h0001);
        rd(4'd4, v); chk("R13 mask lo after reset", v, 16'h00FF);
        rd(4'd5, v); chk("R13 mask hi after reset", v, 16'h00FF);
        rd(4'd6, v); chk("R13 status after reset", v, 16'h0000);

        // map 0 (R1, R5)
        wr(4'd0, 16'hAA34); wr(4'd1, 16'h5512);
        rd(4'd0, v); chk("R5 pointer lo reads bit0 set", v, 16'h0035);
        rd(4'd1, v); chk("R1 pointer hi", v, 16'h0012);
        wr(4'd2, 16'h0078); wr(4'd3, 16'h0056);
        rd(4'd2, v); chk("R1 data lo", v, 16'h0078);
        rd(4'd3, v); chk("R1 data hi", v, 16'h0056);
        wr(4'd15, 16'h00AB);
        rd(4'd7, v); chk("R10 irq write sets flag", v, 16'h0041);
        chk("R12 pins gated while disabled", flag_pins, 0);
        rd(4'd9, v); chk("R1 select 9 is irq hi", v, 16'h00AB);
        rd(4'd7, v); chk("R10 irq hi read clears flag", v, 16'h0001);

        // pin mirroring (R12, R11)
        wr(4'd7, 16'h0005);
        c0 = n_chg;
        wr(4'd8, 16'h0011);
        chk("R12 pins after irq write", flag_pins, 2'b10);
        rd(4'd8, v);
        chk("R12 pins after irq read", flag_pins, 2'b00);
        wr(4'd8, 16'h0022); wr(4'd8, 16'h0033);
        chk("R12 change count", n_chg - c0, 3);
        wr(4'd7, 16'h0025);
        rd(4'd7, v); chk("R11 ctrl write keeps flags", v, 16'h0045);
        rd(4'd9, v);

        // map 1 (R2)
        wr(4'd7, 16'h0007);
        wr(4'd12, 16'h00EF); wr(4'd13, 16'h00CD);
        rd(4'd12, v); chk("R2 second data lo", v, 16'h00EF);
        rd(4'd13, v); chk("R2 second data hi", v, 16'h00CD);
        wr(4'd8, 16'h0022);
        rd(4'd7, v); chk("R2 irq lo write leaves flag", v, 16'h0007);
        rd(4'd8, v); chk("R2 irq lo", v, 16'h0022);
        rd(4'd14, v); chk("R2 reserved select", v, 16'h00FF);

        // halfword DMA (R6, R7, R8, R9)
        wr(4'd7, 16'h001F); wr(4'd11, 16'h0005);
        l0 = n_ld;
        wr(4'd0, 16'h0011);
        chk("R6 lo pointer write no load", n_ld - l0, 0);
        c0 = n_chg;
        wr(4'd1, 16'h0022);
        chk("R6 load issued", n_ld - l0, 1);
        rd(4'd7, v); chk("R6 load sets data-full", v, 16'h003F);
        chk("R6 load leaves pins", n_chg - c0, 0);
        rd(4'd2, v); chk("R6 halfword load data", v, {8'h00, memf(24'h052210)[7:0]});
        rd(4'd3, v); chk("R9 hi read returns old data", v, {8'h00, memf(24'h052210)[15:8]});
        chk("R9 load after advance", n_ld - l0, 2);
        chk("R9 pins after read load", flag_pins, 2'b01);
        rd(4'd0, v); chk("R9 pointer advanced once", v, 16'h0013);
        rd(4'd2, v); chk("R9 data from advanced address", v, {8'h00, memf(24'h052212)[7:0]});
        s0 = n_st;
        wr(4'd2, 16'h009A); wr(4'd3, 16'h00BC);
        chk("R7 store issued", n_st - s0, 1);
        chk("R7 store address", w_addr, 24'h052214);
        chk("R7 store data", {w_word, w_data[15:0]}, {1'b0, 16'hBC9A});
        rd(4'd7, v); chk("R7 store clears data-full", v, 16'h001F);
        chk("R7 pins after store", flag_pins, 2'b00);
        rd(4'd0, v); chk("R8 advance after store", v, 16'h0017);
        wr(4'd0, 16'h00FE); wr(4'd1, 16'h00FF);
        wr(4'd2, 16'h0001); wr(4'd3, 16'h0002);
        chk("R8 store before carry", w_addr, 24'h05FFFE);
        rd(4'd11, v); chk("R8 carry into extension", v, 16'h0006);
        rd(4'd0, v); chk("R8 pointer wrapped", v, 16'h0001);

        // word DMA (R6, R7, R8)
        wr(4'd10, 16'h0001);
        wr(4'd0, 16'h0007); wr(4'd1, 16'h0000);
        rd(4'd12, v); chk("R6 word load low half", v, {8'h00, memf(24'h060004)[7:0]});
        rd(4'd13, v); chk("R6 word load low half hi", v, {8'h00, memf(24'h060004)[15:8]});
        wr(4'd2, 16'h0044); wr(4'd3, 16'h0033);
        chk("R7 word store address", w_addr, 24'h060004);
        chk("R7 word store data", {w_word, w_data}, {1'b1, 16'h3344, memf(24'h060004)[15:0]});
        rd(4'd0, v); chk("R8 word advance", v, 16'h000B);

        // map 3 (R4)
        wr(4'd10, 16'h0003);
        rd(4'd7, v); chk("R4 ctrl full", v, 16'h031F);
        wr(4'd4, 16'h1234);
        rd(4'd4, v); chk("R4 mask full", v, 16'h1234);
        rd(4'd1, v); chk("R4 reserved odd select", v, 16'hFFFF);
        wr(4'd6, 16'hABCD);
        rd(4'd6, v); chk("R4 status low byte only", v, 16'h00CD);

        // random traffic in map 3 with word DMA
        wr(4'd11, 16'h003F);
        m_ext = 8'h3F; m_emask = 16'h1234;
        m_ptr = 16'($urandom);
        wr(4'd0, m_ptr);
        a = {m_ext, m_ptr[15:2], 2'b00};
        m_dat = memf(a)[31:16]; m_dat2 = memf(a)[15:0];
        for (int i = 0; i < 300; i++) begin
            int op;
            logic [15:0] d;
            op = $urandom % 6;
            d  = 16'($urandom);
            case (op)
                0: begin wr(4'd4, d); m_emask = d; end
                1: begin rd(4'd4, v); chk("R4 random mask", v, m_emask); end
                2: begin wr(4'd12, d); m_dat2 = d; end
                3: begin rd(4'd12, v); chk("R4 random second data", v, m_dat2); end
                4: begin
                    wr(4'd2, d); m_dat = d;
                    chk("R7 random store address", w_addr, {m_ext, m_ptr[15:2], 2'b00});
                    chk("R7 random store data", w_data, {m_dat, m_dat2});
                    chk("R7 random pins", flag_pins, 2'b00);
                    sum = {1'b0, m_ptr} + 17'd4;
                    m_ptr = sum[15:0]; m_ext = m_ext + 8'(sum[16]);
                end
                default: begin
                    rd(4'd2, v); chk("R9 random read data", v, m_dat);
                    sum = {1'b0, m_ptr} + 17'd4;
                    m_ptr = sum[15:0]; m_ext = m_ext + 8'(sum[16]);
                    a = {m_ext, m_ptr[15:2], 2'b00};
                    m_dat = memf(a)[31:16]; m_dat2 = memf(a)[15:0];
                    chk("R9 random pins", flag_pins, 2'b01);
                end
            endcase
        end
        rd(4'd0, v); chk("R8 random pointer", v, m_ptr | 16'h0001);
        rd(4'd11, v); chk("R8 random extension", v, {8'h00, m_ext});

        // map 2 (R3)
        wr(4'd7, 16'h021D);
        rd(4'd7, v); chk("R3 ctrl unreachable", v, 16'h00FF);
        rd(4'd0, v); chk("R3 pointer unreachable", v, 16'h00FF);
        wr(4'd7, 16'h0000);
        chk("R3 write ignored core_run", core_run, 1);
        rd(4'd12, v); chk("R3 still reserved after write", v, 16'h00FF);

        // soft reset (R13)
        hw_reset();
        rd(4'd7, v); chk("R13 ctrl after hw reset", v, 16'h0001);
        wr(4'd4, 16'h0000); wr(4'd5, 16'h0000); wr(4'd6, 16'h0077);
        wr(4'd7, 16'h0000);
        chk("R13 halted", core_run, 0);
        wr(4'd7, 16'h000D);
        chk("R13 run after rising bit", core_run, 1);
        rd(4'd7, v); chk("R13 soft reset ctrl", v, 16'h0001);
        rd(4'd4, v); chk("R13 soft reset mask", v, 16'h00FF);
        rd(4'd6, v); chk("R13 soft reset status", v, 16'h0000);

        finish_run();
    end

    // R14: busy mirrors the open request as seen at the ports
    always @(negedge clk) if (!rst && mem_req && !host_busy) begin
        n_chk++; n_fail++;
        $display("FAIL R14 busy low with open request actual=%b expected=%b", host_busy, 1'b1);
    end

endmodule